// File: doc/BRIEF.md
# Byte ALU Execution Stage

This block is the execute stage of a small 8-bit processor core. Each clock cycle it can take one 16-bit instruction word, marked by a valid strobe. It reads the operands from a 32-entry by 8-bit register file, computes the result and writes it back in the same cycle. It also updates a six-bit status word holding carry, zero, negative, overflow, sign and half-carry.

The stage handles four groups of instructions:
- the two-register arithmetic and logic group,
- the two compare forms, which only update the flags,
- the single-register and register-pair copies,
- the single-register group: complement, negate, nibble swap, increment, decrement and the three right shifts.

Any other word is treated as a no-operation. Fetch, memory access, branching and interrupts belong to other stages.

A debug port lets a test or a monitor read any register and the status word. The status output `dbg_flags` uses bit 0 = C, bit 1 = Z, bit 2 = N, bit 3 = V, bit 4 = S and bit 5 = H.

Top module: `byte_exec_stage`

## Requirements
- R1: A synchronous active-high reset clears all 32 registers and all six flags to zero.
- R2: Two-register words have opcode in bits 15:10, destination index {bit 8, bits 7:4} and source index {bit 9, bits 3:0`}`. The codes are 000011 add, 000111 add-with-carry, 000110 subtract and 000010 subtract-with-carry. Each writes its result to the destination at the clock edge where it is presented. Each sets C to the carry or borrow out of bit 7, H to the carry or borrow out of bit 3, and V to the signed overflow.
- R3: Codes 001000 AND, 001010 OR and 001001 XOR write the result, clear V, and leave C and H unchanged. Code 001011 copies the source to the destination and leaves every flag unchanged.
- R4: Codes 000101 (compare) and 000001 (compare-with-carry) set the flags exactly as subtract and subtract-with-carry would, and leave every register unchanged.
- R5: Add-with-carry, subtract-with-carry and compare-with-carry take C from the status word as their incoming carry. For subtract-with-carry and compare-with-carry, Z is cleared when the 8-bit result is nonzero and is otherwise kept.
- R6: Single-register words are 1001 010d dddd xxxx, with the register index in bits 8:4. The low nibble selects the operation: 0000 complement (C set to 1, V cleared), 0001 negate (computed as 0 − value), 0010 swap nibbles (no flag change), 0011 increment, 1010 decrement.
- R7: Low nibbles 0101 (arithmetic right shift), 0110 (logical right shift) and 0111 (rotate right through carry, with the old C entering bit 7) set C to the old bit 0 and set V to N XOR C.
- R8: Increment and decrement leave C and H unchanged. V is set only when increment starts at 0x7F or decrement starts at 0x80. Negate sets C when the result is nonzero and sets V when the result is 0x80.
- R9: Word 0000 0001 dddd rrrr copies register pair 2·rrrr, 2·rrrr+1 to pair 2·dddd, 2·dddd+1 in one cycle and changes no flag.
- R10: S always equals N XOR V, and every flag-updating operation sets N to bit 7 of its result.
- R11: A word that matches no pattern above, or any cycle with the valid strobe low, changes no register and no flag.
- R12: `dbg_data` shows, one cycle after `dbg_sel` is sampled, the register content from before that same clock edge. `dbg_flags` is the status register itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is to be executed this cycle |
| instr | input | 16 | Instruction word |
| dbg_sel | input | 5 | Register index for the debug read |
| dbg_data | output | 8 | Registered content of the selected register |
| dbg_flags | output | 6 | Status register {H,S,V,N,Z,C} |

## Verification
The properties assume that `instr` carries a meaningful word whenever `instr_valid` is high, and that reset is held for at least one edge before the first instruction. They also assume the status output starts from its cleared value; the sign rule and the flag-hold checks depend on it.

The stimulus keeps the valid strobe and the word stable across each edge by driving them at the falling edge. It mixes directed sequences that create carry, overflow and zero-chain cases with random words from every group, including idle cycles and words outside the decoded set.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int DATA_W  = 8;
  localparam int REG_NUM = 32;
  localparam int IDX_W   = $clog2(REG_NUM);
  localparam int INSN_W  = 16;

  typedef enum logic [4:0] {
    OP_NOP, OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_AND, OP_OR, OP_EOR, OP_MOV,
    OP_CP, OP_CPC, OP_MOVW, OP_COM, OP_NEG, OP_SWAP, OP_INC, OP_ASR,
    OP_LSR, OP_ROR, OP_DEC
  } op_e;

  typedef struct packed {
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;

  typedef struct packed {
    op_e              op;
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] src;
    logic             wr_res;
    logic             upd_flags;
    logic             pair;
  } dec_t;
endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
(
  input  logic [INSN_W-1:0] instr,
  output dec_t              dec
);
  always_comb begin
    dec           = '0;
    dec.op        = OP_NOP;
    dec.dst       = {instr[8], instr[7:4]};
    dec.src       = {instr[9], instr[3:0]};
    if (instr[15:8] == 8'h01) begin
      dec.op      = OP_MOVW;
      dec.dst     = {instr[7:4], 1'b0};
      dec.src     = {instr[3:0], 1'b0};
      dec.wr_res  = 1'b1;
      dec.pair    = 1'b1;
    end else if (instr[15:9] == 7'b1001010) begin
      case (instr[3:0])
        4'h0:    dec.op = OP_COM;
        4'h1:    dec.op = OP_NEG;
        4'h2:    dec.op = OP_SWAP;
        4'h3:    dec.op = OP_INC;
        4'h5:    dec.op = OP_ASR;
        4'h6:    dec.op = OP_LSR;
        4'h7:    dec.op = OP_ROR;
        4'hA:    dec.op = OP_DEC;
        default: dec.op = OP_NOP;
      endcase
      dec.wr_res    = (dec.op != OP_NOP);
      dec.upd_flags = (dec.op != OP_NOP) && (dec.op != OP_SWAP);
    end else begin
      case (instr[15:10])
        6'b000011: dec.op = OP_ADD;
        6'b000111: dec.op = OP_ADC;
        6'b000110: dec.op = OP_SUB;
        6'b000010: dec.op = OP_SBC;
        6'b001000: dec.op = OP_AND;
        6'b001010: dec.op = OP_OR;
        6'b001001: dec.op = OP_EOR;
        6'b001011: dec.op = OP_MOV;
        6'b000101: dec.op = OP_CP;
        6'b000001: dec.op = OP_CPC;
        default:   dec.op = OP_NOP;
      endcase
      dec.wr_res    = !(dec.op inside {OP_NOP, OP_CP, OP_CPC});
      dec.upd_flags = !(dec.op inside {OP_NOP, OP_MOV});
    end
  end
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
(
  input  op_e               op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  flags_t            fin,
  output logic [DATA_W-1:0] res,
  output flags_t            fout
);
  logic [DATA_W:0]   add_w, sub_w;
  logic [4:0]        add_h, sub_h;
  logic [DATA_W-1:0] sa, sb;
  logic              cin;

  always_comb begin
    sa    = (op == OP_NEG) ? '0 : a;
    sb    = (op == OP_NEG) ? a : b;
    cin   = (op inside {OP_ADC, OP_SBC, OP_CPC}) ? fin.c : 1'b0;
    add_w = {1'b0, a} + {1'b0, b} + (DATA_W+1)'(cin);
    add_h = {1'b0, a[3:0]} + {1'b0, b[3:0]} + 5'(cin);
    sub_w = {1'b0, sa} - {1'b0, sb} - (DATA_W+1)'(cin);
    sub_h = {1'b0, sa[3:0]} - {1'b0, sb[3:0]} - 5'(cin);
    res   = a;
    fout  = fin;
    case (op)
      OP_ADD, OP_ADC: begin
        res    = add_w[DATA_W-1:0];
        fout.c = add_w[DATA_W];
        fout.h = add_h[4];
        fout.v = (a[7] & b[7] & ~res[7]) | (~a[7] & ~b[7] & res[7]);
      end
      OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
        res    = sub_w[DATA_W-1:0];
        fout.c = sub_w[DATA_W];
        fout.h = sub_h[4];
        fout.v = (sa[7] & ~sb[7] & ~res[7]) | (~sa[7] & sb[7] & res[7]);
      end
      OP_AND:  begin res = a & b; fout.v = 1'b0; end
      OP_OR:   begin res = a | b; fout.v = 1'b0; end
      OP_EOR:  begin res = a ^ b; fout.v = 1'b0; end
      OP_MOV, OP_MOVW: res = b;
      OP_COM:  begin res = ~a; fout.c = 1'b1; fout.v = 1'b0; end
      OP_SWAP: res = {a[3:0], a[7:4]};
      OP_INC:  begin res = a + 1'b1; fout.v = (a == 8'h7F); end
      OP_DEC:  begin res = a - 1'b1; fout.v = (a == 8'h80); end
      OP_ASR:  begin res = {a[7], a[7:1]};  fout.c = a[0]; end
      OP_LSR:  begin res = {1'b0, a[7:1]};  fout.c = a[0]; end
      OP_ROR:  begin res = {fin.c, a[7:1]}; fout.c = a[0]; end
      default: ;
    endcase
    fout.n = res[7];
    if (op inside {OP_SBC, OP_CPC})
      fout.z = (res == '0) ? fin.z : 1'b0;
    else
      fout.z = (res == '0);
    if (op inside {OP_ASR, OP_LSR, OP_ROR})
      fout.v = fout.n ^ fout.c;
    fout.s = fout.n ^ fout.v;
  end
endmodule

// File: rtl/exu_regfile.sv
module exu_regfile #(
  parameter int NREG = 32,
  parameter int DW   = 8,
  parameter int NRD  = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NRD-1:0][AW-1:0]  rd_addr,
  output logic [NRD-1:0][DW-1:0]  rd_data,
  input  logic [1:0]              we,
  input  logic [1:0][AW-1:0]      wa,
  input  logic [1:0][DW-1:0]      wd
);
  logic [DW-1:0] mem [NREG];

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = mem[rd_addr[p]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else begin
      for (int k = 0; k < 2; k++)
        if (we[k]) mem[wa[k]] <= wd[k];
    end
  end
endmodule

// File: rtl/byte_exec_stage.sv
module byte_exec_stage
  import exu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [15:0]       instr,
  input  logic [4:0]        dbg_sel,
  output logic [7:0]        dbg_data,
  output logic [5:0]        dbg_flags
);
  localparam int NRD = 4;

  dec_t                          dec;
  flags_t                        flags_q, alu_flags;
  logic [DATA_W-1:0]             alu_res;
  logic [NRD-1:0][IDX_W-1:0]     rd_addr;
  logic [NRD-1:0][DATA_W-1:0]    rd_data;
  logic [1:0]                    we;
  logic [1:0][IDX_W-1:0]         wa;
  logic [1:0][DATA_W-1:0]        wd;

  exu_decode u_dec (.instr(instr), .dec(dec));

  assign rd_addr[0] = dec.dst;
  assign rd_addr[1] = dec.src;
  assign rd_addr[2] = {dec.src[IDX_W-1:1], 1'b1};
  assign rd_addr[3] = dbg_sel;

  exu_alu u_alu (
    .op(dec.op), .a(rd_data[0]), .b(rd_data[1]), .fin(flags_q),
    .res(alu_res), .fout(alu_flags)
  );

  assign we[0] = instr_valid && dec.wr_res;
  assign wa[0] = dec.dst;
  assign wd[0] = alu_res;
  assign we[1] = instr_valid && dec.pair;
  assign wa[1] = {dec.dst[IDX_W-1:1], 1'b1};
  assign wd[1] = rd_data[2];

  exu_regfile #(.NREG(REG_NUM), .DW(DATA_W), .NRD(NRD)) u_rf (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data),
    .we(we), .wa(wa), .wd(wd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q  <= '0;
      dbg_data <= '0;
    end else begin
      if (instr_valid && dec.upd_flags) flags_q <= alu_flags;
      dbg_data <= rd_data[3];
    end
  end

  assign dbg_flags = flags_q;
endmodule

// File: rtl/byte_exec_stage_chk.sv
module byte_exec_stage_chk (
  input logic        clk,
  input logic        rst,
  input logic        instr_valid,
  input logic [15:0] instr,
  input logic [5:0]  dbg_flags
);
  logic rst_seen = 1'b0;
  always_ff @(posedge clk) rst_seen <= rst;

  logic single_grp;
  assign single_grp = instr_valid && (instr[15:9] == 7'b1001010);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst_seen |-> dbg_flags == 6'h00);  // R1

  AST_SIGN_RULE: assert property (@(posedge clk) disable iff (rst)
    dbg_flags[4] == (dbg_flags[2] ^ dbg_flags[3]));  // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> $stable(dbg_flags));  // R11

  AST_LOGIC_CLEARS_V: assert property (@(posedge clk) disable iff (rst)
    instr_valid && (instr[15:10] inside {6'b001000, 6'b001010, 6'b001001})
    |=> !dbg_flags[3]);  // R3

  AST_INCDEC_KEEP_C: assert property (@(posedge clk) disable iff (rst)
    single_grp && (instr[3:0] inside {4'h3, 4'hA})
    |=> dbg_flags[0] == $past(dbg_flags[0]));  // R8

  AST_COMPL_SETS_C: assert property (@(posedge clk) disable iff (rst)
    single_grp && instr[3:0] == 4'h0 |=> dbg_flags[0]);  // R6

  AST_SHIFT_V: assert property (@(posedge clk) disable iff (rst)
    single_grp && (instr[3:0] inside {4'h5, 4'h6, 4'h7})
    |=> dbg_flags[3] == (dbg_flags[2] ^ dbg_flags[0]));  // R7
endmodule

bind byte_exec_stage byte_exec_stage_chk u_chk (
  .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
  .dbg_flags(dbg_flags)
);

// File: tb/byte_exec_stage_test.sv
module byte_exec_stage_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic [4:0]  dbg_sel = '0;
  logic [7:0]  dbg_data;
  logic [5:0]  dbg_flags;

  byte_exec_stage uut (.*);

  always #5 clk = ~clk;

  int checks = 0, bad = 0;
  bit finished = 0;
  logic [7:0] m [32];
  bit fc, fz, fn, fv, fs, fh;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] w2(logic [5:0] code, logic [4:0] d, logic [4:0] r);
    return {code, r[4], d[4], d[3:0], r[3:0]};
  endfunction
  function automatic logic [15:0] w1(logic [4:0] d, logic [3:0] sub);
    return {7'b1001010, d, sub};
  endfunction

  function automatic int sgn(int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  task automatic model(logic [15:0] w, output string tag);
    int d, r, a, b, res, sres, cin;
    bit wr, fl, zchain;
    d = {w[8], w[7:4]}; r = {w[9], w[3:0]};
    a = m[d]; b = m[r]; cin = 0; wr = 0; fl = 0; zchain = 0; res = a;
    tag = "R11";
    if (w[15:8] == 8'h01) begin
      tag = "R9";
      m[w[7:4]*2] = m[w[3:0]*2];
      m[w[7:4]*2+1] = m[w[3:0]*2+1];
      return;
    end
    if (w[15:9] == 7'b1001010) begin
      fl = 1; wr = 1;
      case (w[3:0])
        4'h0: begin tag = "R6"; res = 255 - a; fc = 1; fv = 0; end
        4'h1: begin tag = "R8"; res = -a; fc = (a != 0); fh = ((a & 15) != 0);
                    fv = (sgn(a) == -128); end
        4'h2: begin tag = "R6"; res = ((a & 15) << 4) | (a >> 4); fl = 0; end
        4'h3: begin tag = "R8"; res = a + 1; fv = (sgn(a) + 1 > 127); end
        4'hA: begin tag = "R8"; res = a - 1; fv = (sgn(a) - 1 < -128); end
        4'h5, 4'h6, 4'h7: begin
          tag = "R7";
          res = a >> 1;
          if (w[3:0] == 4'h5 && a >= 128) res += 128;
          if (w[3:0] == 4'h7 && fc) res += 128;
          fc = a[0];
        end
        default: begin fl = 0; wr = 0; end
      endcase
    end else begin
      case (w[15:10])
        6'b000011, 6'b000111: begin
          tag = (w[12]) ? "R5" : "R2";
          cin = w[12] ? int'(fc) : 0;
          res = a + b + cin; sres = sgn(a) + sgn(b) + cin;
          fh = ((a & 15) + (b & 15) + cin) > 15; fc = res > 255;
          fv = (sres > 127) || (sres < -128); wr = 1; fl = 1;
        end
        6'b000110, 6'b000010, 6'b000101, 6'b000001: begin
          zchain = !w[12];
          tag = zchain ? "R5" : "R2";
          if (!w[11]) tag = "R4";
          cin = zchain ? int'(fc) : 0;
          res = a - b - cin; sres = sgn(a) - sgn(b) - cin;
          fh = ((a & 15) - (b & 15) - cin) < 0; fc = res < 0;
          fv = (sres > 127) || (sres < -128); wr = w[11]; fl = 1;
        end
        6'b001000: begin tag = "R3"; res = a & b; fv = 0; wr = 1; fl = 1; end
        6'b001010: begin tag = "R3"; res = a | b; fv = 0; wr = 1; fl = 1; end
        6'b001001: begin tag = "R3"; res = a ^ b; fv = 0; wr = 1; fl = 1; end
        6'b001011: begin tag = "R3"; res = b; wr = 1; end
        default: ;
      endcase
    end
    res = res & 255;
    if (fl) begin
      fn = (res >= 128);
      if (w[3:0] inside {4'h5, 4'h6, 4'h7} && w[15:9] == 7'b1001010) fv = fn ^ fc;
      if (zchain) fz = (res == 0) ? fz : 0; else fz = (res == 0);
      fs = fn ^ fv;
    end
    if (wr) m[d] = res[7:0];
  endtask

  task automatic step(bit v, logic [15:0] w, logic [4:0] sel, string rtag);
    string tag;
    logic [7:0] exp_d;
    instr_valid = v; instr = w; dbg_sel = sel;
    exp_d = m[sel];
    tag = "R11";
    if (v) model(w, tag);
    @(posedge clk); #1;
    @(negedge clk);
    chk({tag, " flags"}, dbg_flags, {fh, fs, fv, fn, fz, fc});
    chk({rtag, " dbg_data"}, dbg_data, exp_d);
    chk("R10 sign", dbg_flags[4], dbg_flags[2] ^ dbg_flags[3]);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    for (int i = 0; i < 32; i++) m[i] = 8'h5A;
    {fc, fz, fn, fv, fs, fh} = 6'b111111;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) m[i] = 8'h00;
    {fc, fz, fn, fv, fs, fh} = '0;
    chk("R1 flags after reset", dbg_flags, 0);
    for (int i = 0; i < 32; i++) step(0, 16'h0000, 5'(i), "R1");
    // directed: build values, carry, overflow, zero chain
    step(1, w1(5'd0, 4'h0), 5'd0, "R12");          // COM r0 -> FF
    step(1, w1(5'd1, 4'h3), 5'd0, "R12");          // INC r1 -> 01
    step(1, w2(6'b000011, 5'd0, 5'd1), 5'd1, "R12"); // ADD r0,r1 -> 00, C,Z,H
    step(1, w2(6'b000111, 5'd2, 5'd1), 5'd0, "R12"); // ADC carry in
    step(1, w1(5'd3, 4'h0), 5'd2, "R12");
    step(1, w1(5'd3, 4'h7), 5'd3, "R12");          // ROR -> 7F or FF
    step(1, w1(5'd3, 4'h6), 5'd3, "R12");          // LSR
    step(1, w1(5'd3, 4'h3), 5'd3, "R12");          // INC
    step(1, w1(5'd4, 4'h1), 5'd3, "R12");          // NEG of zero
    step(1, w2(6'b000101, 5'd3, 5'd1), 5'd3, "R12"); // CP, r3 unchanged
    step(1, w2(6'b000001, 5'd3, 5'd3), 5'd3, "R12"); // CPC, Z chain
    step(1, {8'h01, 4'd8, 4'd1}, 5'd2, "R12");     // MOVW r17:16 <- r3:2
    step(1, 16'h9408, 5'd16, "R12");               // unmatched word
    step(1, 16'hFFFF, 5'd17, "R12");
    for (int n = 0; n < 4000; n++) begin
      int k;
      logic [5:0] code;
      k = $urandom_range(0, 9);
      case (k)
        0, 1, 2: begin
          case ($urandom_range(0, 9))
            0: code = 6'b000011; 1: code = 6'b000111; 2: code = 6'b000110;
            3: code = 6'b000010; 4: code = 6'b001000; 5: code = 6'b001010;
            6: code = 6'b001001; 7: code = 6'b001011; 8: code = 6'b000101;
            default: code = 6'b000001;
          endcase
          w = w2(code, 5'($urandom_range(0, 31)), 5'($urandom_range(0, 31)));
        end
        3, 4, 5: w = w1(5'($urandom_range(0, 31)), 4'($urandom_range(0, 15)));
        6: w = {8'h01, 8'($urandom)};
        7: w = 16'($urandom);
        default: w = w1(5'($urandom_range(0, 31)), 4'h3);
      endcase
      step(($urandom_range(0, 7) != 0), w, 5'(n), "R12");
    end
    for (int i = 0; i < 32; i++) step(0, 16'h0000, 5'(i), "R12");
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule